// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that owns a small bank of eight-bit control registers. The registers drive parallel outputs into the rest of the chip. The block samples the serial clock and data lines with the system clock. It detects bus conditions and bit edges in that domain, and it pulls the data line low through an enable when it acknowledges or sends a zero.

The slave has no register addressing. A write starts with the write address. The master then sends two bytes that the slave acknowledges and throws away. Every byte after those two lands in register 0, then register 1, and so on. A read starts with the read address. The slave answers with a length byte, then the registers in order, then a fixed identification byte. The master may end either transfer after any complete byte. Each new transaction starts again at register 0.

Top module: `bcfg_slave`

## Requirements
- R1: Reset state. While reset is held and right after it is released, `sdaOe` is 0. `regOut` holds the defaults, with register k in bits [8k+7:8k]: register 0 is 00h and registers 1 to 5 are FFh.
- R2: Address match. The slave acknowledges an address byte only when its upper seven bits equal 69h, that is D2h for a write or D3h for a read. An acknowledge means `sdaOe` is held at 1 through the ninth SCL pulse. For any other address the slave drives nothing and changes no register until the next START.
- R3: Write stream. After D2h the slave acknowledges every byte. The first two bytes are discarded. The following data bytes are loaded, MSB first, into register 0, 1, 2 and onward, in that order.
- R4: Commit timing. A register takes its new value on the SCL fall that ends the byte's eighth bit. The acknowledge drive begins on that same fall. A register never changes while SCL is high.
- R5: Early end. A STOP after any complete byte ends the write. Registers not reached keep their values, and the next transaction starts again at register 0.
- R6: Overflow. Data bytes that arrive after the last register are acknowledged and discarded.
- R7: Read stream. After D3h the slave sends, MSB first, a length byte equal to the register count plus one (07h). It then sends registers 0 to 5 in order, then the identification byte C1h, then 00h for any further byte. Each bit appears on SDA after an SCL fall.
- R8: Read end. When the master answers a byte with NACK (SDA high during the ninth pulse), the slave releases SDA. It stays released, even if the master keeps clocking, until the next START.
- R9: The value of `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low reset that loads the register defaults |
| sclIn | input | 1 | Serial clock level seen on the bus |
| sdaIn | input | 1 | Serial data level seen on the bus |
| sdaOe | output | 1 | 1 pulls the data line low |
| regOut | output | 48 | Register contents, register k in bits [8k+7:8k] |

## Verification
Two things happen on the same synchronized SCL fall: a data byte is committed to its register, and the acknowledge drive starts. This fall ends the eighth bit of a data byte. To provoke it, the bench drives one data byte bit by bit and holds SCL high after the eighth bit. While SCL is high, the target register must still show its old value. A few cycles after SCL falls, it must show the new byte while `sdaOe` is asserted. A bound property also requires every change of `regOut` to coincide with a rise of `sdaOe`. Sweeps over all 128 addresses and over write lengths of 0 to 8 data bytes, each followed by a full readback, cover the address match, the register ordering and the overflow bytes.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_TXNEXT
  } ctrlState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } rxPhase_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic clrIdx;
    logic wrReg;
    logic ldCount;
    logic ldNext;
    logic txShift;
  } dpStrobe_t;

endpackage

// File: rtl/bcfg_dpath.sv
module bcfg_dpath
  import bcfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = '0,
  parameter logic [7:0] ID_BYTE = 8'hC1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  dpStrobe_t             stb,
  output logic                  sclRise,
  output logic                  sclFall,
  output logic                  sdaLvl,
  output logic                  startDet,
  output logic                  stopDet,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] regOut
);

  localparam int IDX_W = $clog2(NUM_REGS + 2);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_REGS + 1);
  localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS + 1);

  // synchronizer chains plus one extra stage for edge detection
  logic [SYNC_STAGES:0] sclPipe;
  logic [SYNC_STAGES:0] sdaPipe;
  logic sclCur, sclOld, sdaCur, sdaOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclCur   = sclPipe[SYNC_STAGES-1];
  assign sclOld   = sclPipe[SYNC_STAGES];
  assign sdaCur   = sdaPipe[SYNC_STAGES-1];
  assign sdaOld   = sdaPipe[SYNC_STAGES];
  assign sclRise  = sclCur & ~sclOld;
  assign sclFall  = ~sclCur & sclOld;
  assign sdaLvl   = sdaCur;
  assign startDet = sclCur & sclOld & sdaOld & ~sdaCur;
  assign stopDet  = sclCur & sclOld & ~sdaOld & sdaCur;

  // receive shifter: samples on every rising SCL
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rxByte <= '0;
    else if (sclRise) rxByte <= {rxByte[6:0], sdaCur};
  end

  // byte index shared by write and read streams, saturating
  logic [IDX_W-1:0] byteIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      byteIdx <= '0;
    else if (stb.clrIdx)
      byteIdx <= '0;
    else if ((stb.wrReg || stb.ldNext) && byteIdx != IDX_MAX)
      byteIdx <= byteIdx + 1'b1;
  end

  // register bank
  logic [7:0] regFile [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= REG_INIT[8*g +: 8];
      else if (stb.wrReg && byteIdx == IDX_W'(g))
        regFile[g] <= rxByte;
    end
    assign regOut[8*g +: 8] = regFile[g];
  end

  // next read byte: register, then identification byte, then zero
  logic [7:0] nextByte;

  always_comb begin
    nextByte = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (byteIdx == IDX_W'(k)) nextByte = regFile[k];
    if (byteIdx == IDX_W'(NUM_REGS)) nextByte = ID_BYTE;
  end

  // transmit shifter, MSB first
  logic [7:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txReg <= '1;
    else if (stb.ldCount) txReg <= COUNT_VAL;
    else if (stb.ldNext)  txReg <= nextByte;
    else if (stb.txShift) txReg <= {txReg[6:0], 1'b1};
  end

  assign txBit = txReg[7];

endmodule

// File: rtl/bcfg_ctrl.sv
module bcfg_ctrl
  import bcfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       sdaOe
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  ctrlState_t state;
  rxPhase_t   phase;
  logic [3:0] bitCnt;
  logic       isRead;

  function automatic rxPhase_t nextPhase(rxPhase_t p);
    case (p)
      PH_ADDR: return PH_CMD;
      PH_CMD:  return PH_CNT;
      default: return PH_DATA;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_ADDR;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      phase  <= PH_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            if (phase != PH_ADDR) begin
              state <= ST_ACK;
            end else if (rxByte[7:1] == SLV_ADDR) begin
              state  <= ST_ACK;
              isRead <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (phase == PH_ADDR && isRead) begin
              state <= ST_TX;
              phase <= PH_DATA;
            end else begin
              state <= ST_RX;
              phase <= nextPhase(phase);
            end
          end
        end
        ST_TX: begin
          if (sclRise)
            bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == LAST_BIT)
            state <= ST_RACK;
        end
        ST_RACK: begin
          if (sclRise) state <= sdaLvl ? ST_IDLE : ST_TXNEXT;
        end
        ST_TXNEXT: begin
          if (sclFall) begin
            state  <= ST_TX;
            bitCnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.clrIdx  = startDet;
    stb.wrReg   = (state == ST_RX) && sclFall && (bitCnt == LAST_BIT) && (phase == PH_DATA);
    stb.ldCount = (state == ST_ACK) && sclFall && (phase == PH_ADDR) && isRead;
    stb.ldNext  = (state == ST_TXNEXT) && sclFall;
    stb.txShift = (state == ST_TX) && sclFall && (bitCnt != LAST_BIT);
  end

  assign sdaOe = (state == ST_ACK) || ((state == ST_TX) && !txBit);

endmodule

// File: rtl/bcfg_slave.sv
module bcfg_slave
  import bcfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = 48'hFFFF_FFFF_FF00,
  parameter logic [7:0] ID_BYTE = 8'hC1,
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regOut
);

  dpStrobe_t  stb;
  logic       sclRise, sclFall, sdaLvl, startDet, stopDet, txBit;
  logic [7:0] rxByte;

  bcfg_dpath #(
    .NUM_REGS(NUM_REGS),
    .REG_INIT(REG_INIT),
    .ID_BYTE(ID_BYTE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .stb(stb),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .sdaLvl(sdaLvl),
    .startDet(startDet),
    .stopDet(stopDet),
    .rxByte(rxByte),
    .txBit(txBit),
    .regOut(regOut)
  );

  bcfg_ctrl #(
    .SLV_ADDR(SLV_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .sdaLvl(sdaLvl),
    .startDet(startDet),
    .stopDet(stopDet),
    .rxByte(rxByte),
    .txBit(txBit),
    .stb(stb),
    .sdaOe(sdaOe)
  );

endmodule

// File: rtl/bcfg_checker.sv
module bcfg_checker #(
  parameter int NUM_REGS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regOut
);

  // R1: no drive right after reset release
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rstN) |-> !sdaOe);

  // R9: the enable toggles only in the SCL low phase
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclIn);

  // R4: no register update while SCL is high
  assert_reg_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regOut) |-> !sclIn);

  // R3: every register update starts an acknowledge
  assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regOut) |-> $rose(sdaOe));

endmodule

bind bcfg_slave bcfg_checker #(.NUM_REGS(NUM_REGS)) u_bcfgChecker (
  .clk(clk),
  .rstN(rstN),
  .sclIn(sclIn),
  .sdaOe(sdaOe),
  .regOut(regOut)
);

// File: tb/bcfg_slave_bench.sv
module bcfg_slave_bench;

  localparam int HALF = 8;
  localparam int NREG = 6;
  localparam logic [7:0] ID_EXP = 8'hC1;
  localparam logic [7:0] WR_ADDR = 8'hD2;
  localparam logic [7:0] RD_ADDR = 8'hD3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic mstLow = 1'b0;
  logic sdaOe;
  logic [NREG*8-1:0] regOut;
  wire sdaLine = !(mstLow || sdaOe);

  int nTests = 0;
  int nFail = 0;
  int oeViol = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  bcfg_slave u_bcfg_slave (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclM),
    .sdaIn(sdaLine),
    .sdaOe(sdaOe),
    .regOut(regOut)
  );

  // R9 monitor: enable must not move while SCL is high
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && (sdaOe !== prevOe)) oeViol++;
    prevOe <= sdaOe;
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] packModel();
    logic [47:0] v;
    for (int i = 0; i < NREG; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tBit(input logic b, output logic r);
    waitClk(2);
    mstLow = !b;
    waitClk(HALF - 2);
    sclM = 1'b1;
    waitClk(HALF / 2);
    r = sdaLine;
    waitClk(HALF / 2);
    sclM = 1'b0;
  endtask

  task automatic tStart();
    mstLow = 1'b0;
    sclM = 1'b1;
    waitClk(HALF);
    mstLow = 1'b1;
    waitClk(HALF);
    sclM = 1'b0;
  endtask

  task automatic tStop();
    waitClk(2);
    mstLow = 1'b1;
    waitClk(HALF);
    sclM = 1'b1;
    waitClk(HALF);
    mstLow = 1'b0;
    waitClk(HALF);
  endtask

  task automatic tWrByte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) tBit(d[i], r);
    tBit(1'b1, r);
    ack = !r;
  endtask

  task automatic tRdByte(input logic giveAck, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      tBit(1'b1, r);
      d[i] = r;
    end
    tBit(!giveAck, r);
  endtask

  task automatic readAll(input string tag);
    logic ack;
    logic [7:0] d;
    tStart();
    tWrByte(RD_ADDR, ack);
    chk({"R2 read address ", tag}, ack, 1'b1);
    tRdByte(1'b1, d);
    chk({"R7 length byte ", tag}, d, 8'd7);
    for (int i = 0; i < NREG; i++) begin
      tRdByte(1'b1, d);
      chk({"R7 register byte ", tag}, d, model[i]);
    end
    tRdByte(1'b1, d);
    chk({"R7 id byte ", tag}, d, ID_EXP);
    tRdByte(1'b0, d);
    chk({"R7 past end ", tag}, d, 8'h00);
    tStop();
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic r;
    model[0] = 8'h00;
    for (int i = 1; i < NREG; i++) model[i] = 8'hFF;

    waitClk(5);
    chk("R1 reset regOut", regOut, packModel());
    chk("R1 reset sdaOe", sdaOe, 1'b0);
    rstN = 1'b1;
    waitClk(4);
    chk("R1 after release regOut", regOut, packModel());
    chk("R1 after release sdaOe", sdaOe, 1'b0);

    // R2: sweep every 7-bit address with the write bit
    for (int a = 0; a < 128; a++) begin
      tStart();
      tWrByte({7'(a), 1'b0}, ack);
      chk("R2 address ack", ack, (a == 'h69));
      if (a == 'h69) begin
        tWrByte(8'hEE, ack); chk("R3 command ack", ack, 1'b1);
        tWrByte(8'h77, ack); chk("R3 count ack", ack, 1'b1);
        tWrByte(8'hA5, ack); chk("R3 data ack", ack, 1'b1);
        model[0] = 8'hA5;
      end else begin
        tWrByte(8'h5A, ack);
        chk("R2 ignored byte ack", ack, 1'b0);
      end
      tStop();
    end
    chk("R2 regs after sweep", regOut, packModel());

    // R3 R5 R6: sweep write lengths, read back each time
    for (int k = 0; k <= 8; k++) begin
      tStart();
      tWrByte(WR_ADDR, ack); chk("R2 write address", ack, 1'b1);
      tWrByte(8'(k), ack);   chk("R3 command ack", ack, 1'b1);
      tWrByte(8'(255 - k), ack); chk("R3 count ack", ack, 1'b1);
      for (int i = 0; i < k; i++) begin
        d = 8'(16 * k + 3 * i + 1);
        tWrByte(d, ack);
        if (i < NREG) begin
          chk("R3 data ack", ack, 1'b1);
          model[i] = d;
        end else begin
          chk("R6 overflow ack", ack, 1'b1);
        end
      end
      tStop();
      chk("R5 regs after early stop", regOut, packModel());
      readAll("after length sweep");
    end

    // R4: commit lands on the fall after bit 8, with the acknowledge
    tStart();
    tWrByte(WR_ADDR, ack);
    tWrByte(8'h01, ack);
    tWrByte(8'h02, ack);
    for (int i = 7; i >= 1; i--) tBit(1'(8'h3C >> i), r);
    waitClk(2);
    mstLow = 1'b1;
    waitClk(HALF - 2);
    sclM = 1'b1;
    waitClk(HALF);
    chk("R4 old value while SCL high", regOut[7:0], model[0]);
    chk("R4 no ack while SCL high", sdaOe, 1'b0);
    sclM = 1'b0;
    waitClk(6);
    chk("R4 new value after fall", regOut[7:0], 8'h3C);
    chk("R4 ack with commit", sdaOe, 1'b1);
    model[0] = 8'h3C;
    tBit(1'b1, r);
    tStop();
    chk("R5 other regs kept", regOut, packModel());

    // R8: NACK ends the read; further clocks see a released line
    tStart();
    tWrByte(RD_ADDR, ack);
    chk("R8 read address ack", ack, 1'b1);
    tRdByte(1'b0, d);
    chk("R8 length before nack", d, 8'd7);
    tRdByte(1'b1, d);
    chk("R8 released after nack", d, 8'hFF);
    chk("R8 sdaOe low after nack", sdaOe, 1'b0);
    tStop();
    readAll("after nack");

    chk("R9 sdaOe moves only with SCL low", oeViol, 0);
    finishRun();
  end

endmodule